// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block counts activity on a single asynchronous input line using an 8-bit up-counter. The counter runs in one of two modes. In edge mode it advances once for each transition of the chosen polarity. In gated mode it advances on one of four tick strobes, and only while the input sits at the chosen level.

The input passes through a two-stage synchronizer. It is then sampled once every four system clocks, so that edge detection keeps to the supported maximum input rate of one quarter of the system clock. Two sticky flags report on activity. One is an input-activity flag. In edge mode it marks each counted edge; in gated mode it marks the moment the gate closes. The other is an overflow flag, set when the count wraps. Each flag drives its own interrupt request line when the matching enable bit is set.

Software sees control and count as one 16-bit word with two byte lanes. The flags are cleared by write-one strobes.

Top module: `pulse_acc`

## Requirements
- R1: After reset the count and all control bits are zero, both flags are clear and both interrupt lines are low.
- R2: With regRdata[15]=0 (edge mode), the count rises by one for each transition of the synchronized, quarter-rate-sampled input toward the level in bit 14: bit 14 = 1 counts rising edges, bit 14 = 0 counts falling edges.
- R3: In edge mode, two counted edges are never closer than four clock cycles; toggles faster than the sampling rate are not counted individually.
- R4: With bit 15 = 1 (gated mode), the count rises by one on each cycle in which the tick strobe chosen by bits 13:12 (value n selects tickStb[n]) is high and the sampled input equals bit 14.
- R5: A count step from 0xFF to 0x00 sets ovfFlag.
- R6: edgeFlag is set on each counted edge in edge mode. In gated mode it is set when the sampled input leaves the active level.
- R7: A high edgeClr or ovfClr clears its flag on the next edge. If a set event occurs in the same cycle, the set wins.
- R8: edgeIrq equals edgeFlag gated by bit 11. ovfIrq equals ovfFlag gated by bit 10.
- R9: regWe[1] writes bits 15:10 from regWdata. regWe[0] loads the count from regWdata[7:0]. A count load in the same cycle as an increment takes priority over the increment.
- R10: Bit 9 reads the synchronized input level and cannot be written. Bit 8 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| padIn | input | 1 | Asynchronous input line being accumulated |
| tickStb | input | 4 | Single-cycle tick strobes for gated mode |
| regWe | input | 2 | Byte write enables: [1] control byte, [0] count byte |
| regWdata | input | 16 | Write data for the combined word |
| edgeClr | input | 1 | Write-one clear for edgeFlag |
| ovfClr | input | 1 | Write-one clear for ovfFlag |
| regRdata | output | 16 | Control byte (15:8) and count (7:0) |
| edgeFlag | output | 1 | Input-activity flag |
| ovfFlag | output | 1 | Count wrap flag |
| edgeIrq | output | 1 | Input-activity interrupt request |
| ovfIrq | output | 1 | Overflow interrupt request |

## Verification
Slow square waves in edge mode, first with the rising polarity and then with the falling one, show whether the polarity bit selects the correct transition. Toggles every one, two and three cycles separate true sampling at quarter rate from a counter that follows every raw change. In gated mode, random strobes under long and short gate pulses, run once for each tick select, show whether the select and the gate level are decoded correctly. A preload to 0xFE, together with random loads and clears that collide with increments and set events, exercises overflow, the priority of a load over an increment, and the rule that a set beats a clear.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int CNT_W = 8;
  localparam int REG_W = 2 * CNT_W;
  localparam int NSRC  = 4;
  localparam int SEL_W = $clog2(NSRC);

  typedef struct packed {
    logic             gated;
    logic             pol;
    logic [SEL_W-1:0] sel;
    logic             edgeIe;
    logic             ovfIe;
  } paCfg_t;

  localparam int CFG_W = $bits(paCfg_t);

  typedef struct packed {
    logic inc;
    logic flagSet;
  } paStrobe_t;
endpackage

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_RATIO   = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            padIn,
  input  logic [NSRC-1:0] tickStb,
  input  paCfg_t          cfg,
  output paStrobe_t       strb,
  output logic            pinLvl
);
  localparam int DIV_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DIV_W-1:0]       divCnt;
  logic                   sampleEn;
  logic                   sLvl;
  logic                   towardAct;
  logic                   leaveAct;

  // input synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= padIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], padIn};
      end
    end
  endgenerate

  assign pinLvl = syncQ[SYNC_STAGES-1];

  // quarter-rate sampling enable
  always_ff @(posedge clk) begin
    if (!rstN)                divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  assign sampleEn = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)         sLvl <= 1'b0;
    else if (sampleEn) sLvl <= pinLvl;
  end

  assign towardAct = sampleEn && (pinLvl == cfg.pol) && (sLvl != cfg.pol);
  assign leaveAct  = sampleEn && (pinLvl != cfg.pol) && (sLvl == cfg.pol);

  always_comb begin
    if (cfg.gated) begin
      strb.inc     = tickStb[cfg.sel] && (sLvl == cfg.pol);
      strb.flagSet = leaveAct;
    end else begin
      strb.inc     = towardAct;
      strb.flagSet = towardAct;
    end
  end
endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import pa_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  paStrobe_t        strb,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             cntWe,
  input  logic [CNT_W-1:0] cntWdata,
  input  logic             edgeClr,
  input  logic             ovfClr,
  output paCfg_t           cfg,
  output logic [CNT_W-1:0] count,
  output logic             edgeFlag,
  output logic             ovfFlag
);
  logic wrapNow;

  assign wrapNow = strb.inc && !cntWe && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN)      cfg <= '0;
    else if (cfgWe) cfg <= paCfg_t'(cfgWdata);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         count <= '0;
    else if (cntWe)    count <= cntWdata;
    else if (strb.inc) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (strb.flagSet) edgeFlag <= 1'b1;
      else if (edgeClr) edgeFlag <= 1'b0;
      if (wrapNow)      ovfFlag  <= 1'b1;
      else if (ovfClr)  ovfFlag  <= 1'b0;
    end
  end
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
  import pa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_RATIO   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             padIn,
  input  logic [NSRC-1:0]  tickStb,
  input  logic [1:0]       regWe,
  input  logic [REG_W-1:0] regWdata,
  input  logic             edgeClr,
  input  logic             ovfClr,
  output logic [REG_W-1:0] regRdata,
  output logic             edgeFlag,
  output logic             ovfFlag,
  output logic             edgeIrq,
  output logic             ovfIrq
);
  localparam int RSV_W = CNT_W - CFG_W - 1;

  paCfg_t          cfg;
  paStrobe_t       strb;
  logic            pinLvl;
  logic [CNT_W-1:0] count;
  logic [RSV_W-1:0] unusedWr;

  assign unusedWr = regWdata[CNT_W +: RSV_W];

  pa_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DIV_RATIO(DIV_RATIO)) u_ctrl (
    .clk(clk), .rstN(rstN), .padIn(padIn), .tickStb(tickStb),
    .cfg(cfg), .strb(strb), .pinLvl(pinLvl)
  );

  pa_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgWe(regWe[1]), .cfgWdata(regWdata[REG_W-1 -: CFG_W]),
    .cntWe(regWe[0]), .cntWdata(regWdata[CNT_W-1:0]),
    .edgeClr(edgeClr), .ovfClr(ovfClr),
    .cfg(cfg), .count(count), .edgeFlag(edgeFlag), .ovfFlag(ovfFlag)
  );

  assign regRdata = {cfg, pinLvl, {RSV_W{1'b0}}, count};
  assign edgeIrq  = edgeFlag && cfg.edgeIe;
  assign ovfIrq   = ovfFlag && cfg.ovfIe;
endmodule

// File: rtl/pa_chk.sv
module pa_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cntWe,
  input logic [7:0] cntWdata,
  input logic [7:0] cnt,
  input logic       gated,
  input logic       inc,
  input logic       flagSet,
  input logic       edgeClr,
  input logic       ovfClr,
  input logic       edgeFlag,
  input logic       ovfFlag
);
  // R2
  count_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !cntWe) |=> cnt == $past(cnt) + 8'd1);
  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && !cntWe) |=> $stable(cnt));
  // R9
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |=> cnt == $past(cntWdata));
  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !cntWe && cnt == 8'hFF) |=> ovfFlag);
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagSet |=> edgeFlag);
  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeClr && !flagSet) |=> !edgeFlag);
  // R7
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !(inc && !cntWe && cnt == 8'hFF)) |=> !ovfFlag);
  // R3
  event_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !gated) |=> !inc);
endmodule

bind pulse_acc pa_chk u_chk (
  .clk(clk), .rstN(rstN),
  .cntWe(regWe[0]), .cntWdata(regWdata[7:0]),
  .cnt(regRdata[7:0]), .gated(regRdata[15]),
  .inc(strb.inc), .flagSet(strb.flagSet),
  .edgeClr(edgeClr), .ovfClr(ovfClr),
  .edgeFlag(edgeFlag), .ovfFlag(ovfFlag)
);

// File: tb/tb_pulse_acc.sv
module tb_pulse_acc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        padIn = 1'b0;
  logic [3:0]  tickStb = '0;
  logic [1:0]  regWe = '0;
  logic [15:0] regWdata = '0;
  logic        edgeClr = 1'b0;
  logic        ovfClr = 1'b0;
  logic [15:0] regRdata;
  logic        edgeFlag, ovfFlag, edgeIrq, ovfIrq;

  int vectors = 0;
  int fails = 0;
  bit cmpOn = 0;
  bit randTick = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pulse_acc dut (
    .clk(clk), .rstN(rstN), .padIn(padIn), .tickStb(tickStb),
    .regWe(regWe), .regWdata(regWdata), .edgeClr(edgeClr), .ovfClr(ovfClr),
    .regRdata(regRdata), .edgeFlag(edgeFlag), .ovfFlag(ovfFlag),
    .edgeIrq(edgeIrq), .ovfIrq(ovfIrq)
  );

  // behavioural reference model
  int mCnt, mDiv;
  bit mS1, mS2, mLvl, mGated, mPol, mEIe, mOIe, mEF, mOF;
  int mSel;
  bit smp, inc, fset;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mDiv = 0; mS1 = 0; mS2 = 0; mLvl = 0;
      mGated = 0; mPol = 0; mEIe = 0; mOIe = 0; mSel = 0; mEF = 0; mOF = 0;
    end else begin
      smp = (mDiv == 3);
      if (mGated) begin
        inc  = tickStb[mSel] && (mLvl == mPol);
        fset = smp && (mS2 != mPol) && (mLvl == mPol);
      end else begin
        inc  = smp && (mS2 == mPol) && (mLvl != mPol);
        fset = inc;
      end
      if (inc && !regWe[0] && mCnt == 255) mOF = 1;
      else if (ovfClr) mOF = 0;
      if (fset) mEF = 1;
      else if (edgeClr) mEF = 0;
      if (regWe[0]) mCnt = regWdata[7:0];
      else if (inc) mCnt = (mCnt + 1) % 256;
      if (regWe[1]) begin
        mGated = regWdata[15]; mPol = regWdata[14];
        mSel = regWdata[13:12]; mEIe = regWdata[11]; mOIe = regWdata[10];
      end
      if (smp) mLvl = mS2;
      mS2 = mS1; mS1 = padIn;
      mDiv = (mDiv + 1) % 4;
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      check("R2/R4/R9 count", regRdata[7:0], mCnt);
      check("R9 control", regRdata[15:10],
            {mGated, mPol, mSel[1:0], mEIe, mOIe});
      check("R10 pin mirror", regRdata[9:8], {mS2, 1'b0});
      check("R6 edgeFlag", edgeFlag, mEF);
      check("R5 ovfFlag", ovfFlag, mOF);
      check("R8 edgeIrq", edgeIrq, mEF && mEIe);
      check("R8 ovfIrq", ovfIrq, mOF && mOIe);
    end
  end

  always @(negedge clk) if (randTick) tickStb <= 4'($urandom);

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] we, logic [15:0] d);
    regWe = we; regWdata = d;
    cyc(1);
    regWe = '0;
  endtask

  task automatic toggles(int period, int count);
    for (int i = 0; i < count; i++) begin
      padIn = ~padIn;
      cyc(period);
    end
  endtask

  initial begin
    cyc(5);
    // R1: reset state
    check("R1 rdata", regRdata, 0);
    check("R1 flags", {edgeFlag, ovfFlag, edgeIrq, ovfIrq}, 0);
    rstN = 1'b1;
    cmpOn = 1;
    cyc(3);
    // R2 rising edges, R8 irq enable
    wr(2'b10, 16'h4800);
    toggles(10, 20);
    // R7 clear with no colliding set
    edgeClr = 1; cyc(1); edgeClr = 0;
    // R2 falling edges
    wr(2'b10, 16'h0C00);
    toggles(7, 20);
    // R3 toggles faster than the sampling rate
    toggles(1, 40);
    toggles(2, 40);
    toggles(3, 40);
    // R5 wrap from preload
    wr(2'b01, 16'h00FE);
    toggles(9, 12);
    ovfClr = 1; cyc(1); ovfClr = 0;
    // R4 gated mode, every tick select, both levels
    randTick = 1;
    for (int s = 0; s < 4; s++) begin
      wr(2'b10, 16'hCC00 | (16'(s) << 12));
      toggles(25, 6);
      toggles(3, 8);
      wr(2'b10, 16'h8C00 | (16'(s) << 12));
      toggles(17, 6);
    end
    // R7/R9 random collisions of loads, clears and sets
    for (int i = 0; i < 3000; i++) begin
      padIn   = ($urandom % 5) == 0 ? ~padIn : padIn;
      edgeClr = ($urandom % 4) == 0;
      ovfClr  = ($urandom % 4) == 0;
      regWe   = (($urandom % 10) == 0) ? 2'($urandom) : 2'b00;
      regWdata = 16'($urandom);
      cyc(1);
    end
    regWe = '0; edgeClr = 0; ovfClr = 0; randTick = 0;
    cyc(5);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule